// File: doc/BRIEF.md
# Fractional Baud Rate Tick Generator

This block turns a system clock into the timing ticks a UART needs. A 16-bit integer divisor plus a 4-bit fraction, counted in sixteenths of a clock, sets the length of one oversampling period. A 2-bit field selects how many of those periods make up one bit time: 16, 8 or 4. The outputs are a one-cycle sample tick for every oversampling period and a one-cycle baud tick for every bit time.

The fraction is spread evenly with a 4-bit phase accumulator. Each sample period lasts either D or D+1 clocks, where D is the integer divisor. In any 16 consecutive periods, exactly F of them are stretched, where F is the fraction. A byte-wide register port holds the divisor bytes, the fraction/mode byte and a feature byte. The feature byte arms writes to the fraction/mode byte. While the divisor is zero, tick generation stops and the divisor addresses return fixed identification codes.

Top module: `fracBaudGen`

## Requirements
- R1: Address 0 holds the low divisor byte and address 1 the high byte. The integer divisor D is {high, low}. When D is nonzero, reads at these addresses return the stored bytes.
- R2: While D is zero, a read at address 0 returns 0x02 and a read at address 1 returns 0x01.
- R3: While D is zero, neither sampleTick nor baudTick is ever asserted.
- R4: With D nonzero, every sample period is D or D+1 clocks long. Any 16 consecutive periods add up to exactly 16*D+F clocks, where F is the fraction.
- R5: Address 2 holds the fraction in bits [3:0] and the mode in bits [5:4]. Bits [7:6] always read 0, and writes to them are ignored.
- R6: A write to address 2 takes effect only while bit 4 of the feature byte at address 3 is 1; otherwise it is dropped. Address 3 reads back only bit 4, and its other bits read 0.
- R7: Mode 00 gives one baud tick per 16 sample ticks, 01 one per 8, 10 one per 4, and 11 behaves as 00. A baud tick always coincides with a sample tick.
- R8: After reset all registers are zero, so the block is in 16x mode with no ticks. Address 2 and address 3 read 0.
- R9: An accepted write to address 0, 1 or 2 restarts the generator. The first sample tick is high in the cycle that begins D clock edges after the accepting edge. The first baud tick falls on the Nth sample tick after the restart, where N is the mode's ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| sampleTick | output | 1 | One-cycle oversampling tick |
| baudTick | output | 1 | One-cycle tick per bit time |

## Verification
The hardest property to reach from the ports is the even spread of the fraction. Any single period is only D or D+1 clocks, so one gap says little. The stimulus therefore programs small divisors with fractions of 4 and 15 and times 16 consecutive sample periods. It checks the sum against 16*D+F and the shortest and longest gap against D and D+1. Restart timing is reached by writing a divisor and counting edges from the accepting edge to the first tick.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;
  parameter int DIV_W   = 16;
  parameter int FRAC_W  = 4;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_DIV_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_DIV_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_FRAC   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_FEAT   = 2'd3;

  typedef enum logic [1:0] {
    OVS_16  = 2'b00,
    OVS_8   = 2'b01,
    OVS_4   = 2'b10,
    OVS_RSV = 2'b11
  } ovsMode_e;

  typedef struct packed {
    logic               reload;
    logic [DIV_W-1:0]   divisor;
    logic [FRAC_W-1:0]  frac;
    ovsMode_e           mode;
  } ctrlStrobe_t;
endpackage

// File: rtl/fbg_regs.sv
`timescale 1ns/1ps
module fbg_regs
  import fbg_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_CODE  = 8'h02,
  parameter logic [DATA_W-1:0] REV_CODE = 8'h01,
  parameter int                FEAT_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              featEn,
  output ctrlStrobe_t       ctrl
);
  localparam int PAD_W = DATA_W - FRAC_W - 2;

  logic [DATA_W-1:0] divLo, divHi;
  logic [FRAC_W-1:0] fracQ;
  ovsMode_e          modeQ;
  logic              reloadQ;
  logic              divZero;
  logic              acceptCfg;

  assign divZero   = ({divHi, divLo} == '0);
  assign acceptCfg = wrEn && ((addr == ADR_DIV_LO) || (addr == ADR_DIV_HI) ||
                              ((addr == ADR_FRAC) && featEn));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLo   <= '0;
      divHi   <= '0;
      fracQ   <= '0;
      modeQ   <= OVS_16;
      featEn  <= 1'b0;
      reloadQ <= 1'b0;
    end else begin
      reloadQ <= acceptCfg;
      if (wrEn) begin
        case (addr)
          ADR_DIV_LO: divLo <= wrData;
          ADR_DIV_HI: divHi <= wrData;
          ADR_FRAC: if (featEn) begin
            fracQ <= wrData[FRAC_W-1:0];
            modeQ <= ovsMode_e'(wrData[FRAC_W+1:FRAC_W]);
          end
          default:    featEn <= wrData[FEAT_BIT];
        endcase
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_DIV_LO: rdData = divZero ? ID_CODE  : divLo;
      ADR_DIV_HI: rdData = divZero ? REV_CODE : divHi;
      ADR_FRAC:   rdData = {{PAD_W{1'b0}}, modeQ, fracQ};
      default:    rdData[FEAT_BIT] = featEn;
    endcase
  end

  assign ctrl.reload  = reloadQ;
  assign ctrl.divisor = {divHi, divLo};
  assign ctrl.frac    = fracQ;
  assign ctrl.mode    = modeQ;
endmodule

// File: rtl/fbg_datapath.sv
`timescale 1ns/1ps
module fbg_datapath
  import fbg_pkg::*;
#(
  parameter int MAX_RATIO = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t ctrl,
  output logic        sampleTick,
  output logic        baudTick
);
  localparam int SUB_W = $clog2(MAX_RATIO);

  logic [DIV_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [SUB_W-1:0]  subCnt;
  logic [SUB_W-1:0]  subLimit;
  logic [FRAC_W:0]   phaseSum;
  logic              active;

  always_comb begin
    case (ctrl.mode)
      OVS_8:   subLimit = SUB_W'(MAX_RATIO / 2 - 1);
      OVS_4:   subLimit = SUB_W'(MAX_RATIO / 4 - 1);
      default: subLimit = SUB_W'(MAX_RATIO - 1);
    endcase
  end

  assign active     = (ctrl.divisor != '0);
  assign phaseSum   = {1'b0, acc} + {1'b0, ctrl.frac};
  assign sampleTick = active && !ctrl.reload && (cnt == '0);
  assign baudTick   = sampleTick && (subCnt == subLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      acc    <= '0;
      subCnt <= '0;
    end else if (ctrl.reload) begin
      cnt    <= ctrl.divisor - DIV_W'(1);
      acc    <= '0;
      subCnt <= '0;
    end else if (active) begin
      if (cnt == '0) begin
        acc    <= phaseSum[FRAC_W-1:0];
        cnt    <= ctrl.divisor - DIV_W'(1) + DIV_W'(phaseSum[FRAC_W]);
        subCnt <= baudTick ? '0 : subCnt + SUB_W'(1);
      end else begin
        cnt <= cnt - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/fracBaudGen.sv
`timescale 1ns/1ps
module fracBaudGen
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sampleTick,
  output logic              baudTick
);
  ctrlStrobe_t ctrl;
  logic        featEn;

  fbg_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .featEn(featEn), .ctrl(ctrl)
  );

  fbg_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .sampleTick(sampleTick), .baudTick(baudTick)
  );
endmodule

// File: rtl/fracBaudGen_chk.sv
`timescale 1ns/1ps
module fracBaudGen_chk
  import fbg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              sampleTick,
  input logic              baudTick,
  input logic [DIV_W-1:0]  divisor,
  input logic [FRAC_W-1:0] fracVal,
  input logic [1:0]        modeVal,
  input logic              featEn
);
  logic [DIV_W:0] gapCnt;
  logic           gapValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt   <= '0;
      gapValid <= 1'b0;
    end else begin
      if (wrEn)            gapValid <= 1'b0;
      else if (sampleTick) gapValid <= 1'b1;
      if (sampleTick)             gapCnt <= (DIV_W+1)'(1);
      else if (gapCnt != '1)      gapCnt <= gapCnt + (DIV_W+1)'(1);
    end
  end

  assert_quiet_zero_div_R3: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |-> (!sampleTick && !baudTick));

  assert_baud_on_sample_R7: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> sampleTick);

  assert_period_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && gapValid) |->
      ((gapCnt == {1'b0, divisor}) || (gapCnt == {1'b0, divisor} + (DIV_W+1)'(1))));

  assert_cfg_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_FRAC && featEn) |=>
      (fracVal == $past(wrData[FRAC_W-1:0]) && modeVal == $past(wrData[FRAC_W+1:FRAC_W])));

  assert_locked_cfg_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_FRAC && !featEn) |=> ($stable(fracVal) && $stable(modeVal)));
endmodule

bind fracBaudGen fracBaudGen_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .sampleTick(sampleTick), .baudTick(baudTick),
  .divisor(ctrl.divisor), .fracVal(ctrl.frac), .modeVal(ctrl.mode), .featEn(featEn)
);

// File: tb/fracBaudGen_tb_top.sv
`timescale 1ns/1ps
module fracBaudGen_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sampleTick, baudTick;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fracBaudGen dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sampleTick(sampleTick), .baudTick(baudTick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    check(rdData == exp, tag, rdData, exp);
  endtask

  task automatic measure(input int n, output int total, output int minG, output int maxG);
    int g;
    total = 0; minG = 1 << 30; maxG = 0;
    do @(negedge clk); while (!sampleTick);
    for (int i = 0; i < n; i++) begin
      g = 0;
      do begin @(negedge clk); g++; end while (!sampleTick);
      total += g;
      if (g < minG) minG = g;
      if (g > maxG) maxG = g;
    end
  endtask

  task automatic testReset();
    int seen = 0;
    rdCheck(2'd0, 8'h02, "R2 id low");
    rdCheck(2'd1, 8'h01, "R2 rev high");
    rdCheck(2'd2, 8'h00, "R8 cfg reset");
    rdCheck(2'd3, 8'h00, "R8 feature reset");
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sampleTick || baudTick) seen++;
    end
    check(seen == 0, "R3 R8 no ticks after reset", seen, 0);
  endtask

  task automatic testDivReadback();
    wr(2'd1, 8'h12);
    wr(2'd0, 8'h34);
    rdCheck(2'd0, 8'h34, "R1 low byte");
    rdCheck(2'd1, 8'h12, "R1 high byte");
    wr(2'd1, 8'h00);
    rdCheck(2'd1, 8'h00, "R1 high zero, low nonzero");
  endtask

  task automatic testRestart(input logic [7:0] d);
    int c = 1;
    wr(2'd0, d);
    while (!sampleTick && c < 1000) begin @(negedge clk); c++; end
    check(c == int'(d) + 1, "R9 first tick delay", c, int'(d) + 1);
  endtask

  task automatic testPeriod(input int d, input logic [3:0] f, input string tag);
    int tot, mn, mx;
    wr(2'd3, 8'h10);
    wr(2'd2, {4'h0, f});
    wr(2'd0, d[7:0]);
    measure(16, tot, mn, mx);
    check(tot == 16 * d + int'(f), {tag, " sum of 16"}, tot, 16 * d + int'(f));
    check(mn >= d, {tag, " min gap"}, mn, d);
    check(mx <= d + ((f != 0) ? 1 : 0), {tag, " max gap"}, mx, d + ((f != 0) ? 1 : 0));
  endtask

  task automatic testMode(input logic [1:0] m, input int ratio);
    int s = 0;
    wr(2'd3, 8'h10);
    wr(2'd0, 8'h02);
    wr(2'd2, {2'b00, m, 4'h0});
    while (s < 100) begin
      if (sampleTick) s++;
      if (baudTick) break;
      @(negedge clk);
    end
    check(s == ratio, "R9 first baud after restart", s, ratio);
    s = 0;
    @(negedge clk);
    while (s < 100) begin
      if (sampleTick) s++;
      if (baudTick) break;
      @(negedge clk);
    end
    check(s == ratio, "R7 samples per baud", s, ratio);
  endtask

  task automatic testGate();
    int tot, mn, mx;
    wr(2'd3, 8'hEF);
    rdCheck(2'd3, 8'h00, "R6 feature bit clear");
    wr(2'd2, 8'h21);
    rdCheck(2'd2, 8'h30, "R6 locked write dropped");
    measure(16, tot, mn, mx);
    check(tot == 32, "R6 period unchanged", tot, 32);
    wr(2'd3, 8'hFF);
    rdCheck(2'd3, 8'h10, "R6 feature only bit 4");
  endtask

  task automatic testReserved();
    wr(2'd2, 8'hFF);
    rdCheck(2'd2, 8'h3F, "R5 reserved bits read 0");
    wr(2'd2, 8'hC0);
    rdCheck(2'd2, 8'h00, "R5 reserved write ignored");
  endtask

  task automatic testZero();
    int seen = 0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sampleTick || baudTick) seen++;
    end
    check(seen == 0, "R3 zero divisor silent", seen, 0);
    rdCheck(2'd0, 8'h02, "R2 id after clear");
    rdCheck(2'd1, 8'h01, "R2 rev after clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDivReadback();
    testRestart(8'd5);
    testRestart(8'd1);
    testPeriod(5, 4'h0, "R4 integer");
    testPeriod(3, 4'h4, "R4 frac 4");
    testPeriod(2, 4'hF, "R4 frac 15");
    testMode(2'b00, 16);
    testMode(2'b01, 8);
    testMode(2'b10, 4);
    testMode(2'b11, 16);
    testGate();
    testReserved();
    testZero();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule